// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Controller

This block keeps a digitally controlled oscillator at a programmed multiple of a reference clock. One of three reference clocks is picked, passed through a pre-divider, and used as a measurement window. In each window the controller counts rising edges of the post-divided oscillator clock and compares the count with N + 1. It then moves a combined code up by one, down by one, or leaves it where it is. The code is split into a coarse tap field and a fine modulation field. Once locked, the post-divided clock runs at (N + 1) · f_ref / n and the raw oscillator clock runs D times faster.

The oscillator is a behavioural, synthesizable model clocked by the system clock. It is a phase accumulator that adds the combined code on every cycle, and its top bit is the oscillator clock. Software can stop the loop with a disable control. While the loop is stopped the code holds its value and can be loaded directly. A sticky fault flag reports that the code has reached either end of its range.

Top module: `fll_ctrl`

## Requirements
- R1: After reset the combined code {tap, modulation} is 0, the fault flag is 1, and both oscillator clock outputs are low.
- R2: Reference select encoding: 0 picks the low-frequency crystal input, 2 picks the high-frequency crystal input, and 1 or 3 picks the internal reference input.
- R3: Pre-divider codes 0, 1, 2, 3, 4 and 5 divide the reference by n = 1, 2, 4, 8, 12 and 16. Codes 6 and 7 also divide by 16.
- R4: Post-divider codes 0 to 5 give D = 1, 2, 4, 8, 16 and 32, and codes 6 and 7 give 32. The divided clock makes one rising edge for every D rising edges of the oscillator clock.
- R5: With combined code C, the oscillator clock makes C rising edges every 2^ACC_W system clock cycles (ACC_W = 11 by default).
- R6: While the loop runs, the combined code changes by at most one per system cycle. At each divided-reference edge it steps +1 if the window count was below N + 1 and −1 if it was above, saturating at 0 and at the maximum. The first window after the loop is enabled only starts counting.
- R7: With the loop running, the divided clock settles to (N + 1) · f_ref / n well within n · 1024 reference periods. Over four windows its edge count lies within 1/8 + 3 edges of 4 · (N + 1).
- R8: While the loop is disabled the code holds its value. A load strobe copies the load value into the code on the next clock edge.
- R9: A load strobe while the loop is running has no effect on the code.
- R10: The fault flag is set on the cycle after the code sits at 0 or at its maximum. It stays set until a clear strobe arrives while the code is away from both limits.
- R11: N is 10 bits wide. N = 762 with D = 2 and n = 1 reaches lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_lf | input | 1 | Low-frequency crystal reference |
| ref_hf | input | 1 | High-frequency crystal reference |
| ref_int | input | 1 | Internal reference |
| ref_sel | input | 2 | Reference source select |
| ref_div_sel | input | 3 | Reference pre-divider code |
| mult_n | input | NW (10) | Multiplier N |
| post_div_sel | input | 3 | Post-divider code |
| loop_off | input | 1 | 1 stops the loop and freezes the code |
| code_ld | input | 1 | Load strobe, honoured only while the loop is off |
| code_ld_val | input | TAP_W+MOD_W (10) | Combined code value to load |
| fault_clr | input | 1 | Fault flag clear strobe |
| dco_tap | output | TAP_W (5) | Upper field of the combined code |
| dco_mod | output | MOD_W (5) | Lower field of the combined code |
| dco_clk | output | 1 | Oscillator clock |
| dco_div_clk | output | 1 | Oscillator clock divided by D |
| dco_fault | output | 1 | Sticky limit fault flag |

## Verification
A corrupted window count or a wrong comparison target shows up as a divided clock rate off from (N + 1) · f_ref / n after settling. It can also show up as a code that moves the wrong way in the first few windows after enable. A wrong pre-divider or post-divider ratio shifts the edge counts by a whole factor, so a four-window measurement flags it at once. A fault register or code register that mishandles load, freeze or clear differs at the ports on the very next cycle. The post-divider is swept over every code at a fixed oscillator code, and the pre-divider over every valid code through a full lock.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic [1:0] {
        REF_LF      = 2'd0,
        REF_INT     = 2'd1,
        REF_HF      = 2'd2,
        REF_INT_ALT = 2'd3
    } ref_src_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN
    } step_e;

    typedef struct packed {
        logic clk;
        logic rise;
        logic div_clk;
        logic div_rise;
    } dco_taps_t;

    function automatic logic [4:0] prediv_ratio(input logic [2:0] sel);
        case (sel)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd12;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [5:0] postdiv_ratio(input logic [2:0] sel);
        case (sel)
            3'd0:    return 6'd1;
            3'd1:    return 6'd2;
            3'd2:    return 6'd4;
            3'd3:    return 6'd8;
            3'd4:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/fll_ref_path.sv
module fll_ref_path
    import fll_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ref_in,
    input  logic [1:0] sel,
    input  logic [2:0] div_sel,
    output logic       ref_tick
);
    localparam int NUM_SRC = 3;

    logic [NUM_SRC-1:0] synced;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[SYNC_STAGES-2:0], ref_in[g]};
        end
        assign synced[g] = sh_q[SYNC_STAGES-1];
    end

    logic       picked;
    logic       picked_q;
    logic [4:0] edge_cnt_q;
    logic [4:0] ratio;
    logic       tick_q;

    always_comb begin
        case (ref_src_e'(sel))
            REF_LF:  picked = synced[0];
            REF_HF:  picked = synced[2];
            default: picked = synced[1];
        endcase
    end

    assign ratio = prediv_ratio(div_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            picked_q   <= 1'b0;
            edge_cnt_q <= '0;
            tick_q     <= 1'b0;
        end else begin
            picked_q <= picked;
            tick_q   <= 1'b0;
            if (picked && !picked_q) begin
                if (edge_cnt_q + 5'd1 >= ratio) begin
                    edge_cnt_q <= '0;
                    tick_q     <= 1'b1;
                end else begin
                    edge_cnt_q <= edge_cnt_q + 5'd1;
                end
            end
        end
    end

    assign ref_tick = tick_q;
endmodule

// File: rtl/fll_dco_model.sv
module fll_dco_model
    import fll_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int ACC_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic [2:0]        post_sel,
    output dco_taps_t         taps
);
    logic [ACC_W-1:0] acc_q;
    logic             msb_q;
    logic [4:0]       div_cnt_q;
    logic             div_q;
    logic             div_rise_q;
    logic [5:0]       ratio;
    logic [5:0]       half;
    logic             rise;
    logic             wrap;

    assign ratio = postdiv_ratio(post_sel);
    assign half  = ratio >> 1;
    assign rise  = acc_q[ACC_W-1] & ~msb_q;
    assign wrap  = ({1'b0, div_cnt_q} + 6'd1) >= half;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            msb_q      <= 1'b0;
            div_cnt_q  <= '0;
            div_q      <= 1'b0;
            div_rise_q <= 1'b0;
        end else begin
            acc_q      <= acc_q + ACC_W'(code);
            msb_q      <= acc_q[ACC_W-1];
            div_rise_q <= 1'b0;
            if (ratio == 6'd1) begin
                div_cnt_q <= '0;
                div_q     <= 1'b0;
            end else if (rise) begin
                if (wrap) begin
                    div_cnt_q  <= '0;
                    div_q      <= ~div_q;
                    div_rise_q <= ~div_q;
                end else begin
                    div_cnt_q <= div_cnt_q + 5'd1;
                end
            end
        end
    end

    assign taps.clk      = acc_q[ACC_W-1];
    assign taps.rise     = rise;
    assign taps.div_clk  = (ratio == 6'd1) ? acc_q[ACC_W-1] : div_q;
    assign taps.div_rise = (ratio == 6'd1) ? rise : div_rise_q;
endmodule

// File: rtl/fll_loop.sv
module fll_loop
    import fll_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int NW     = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              div_rise,
    input  logic              loop_off,
    input  logic [NW-1:0]     mult_n,
    input  logic              ld,
    input  logic [CODE_W-1:0] ld_val,
    input  logic              fault_clr,
    output logic [CODE_W-1:0] code,
    output logic              fault
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  target;
    logic              primed_q;
    logic              fault_q;
    logic              at_lim;
    step_e             step;

    assign target = CNT_W'(mult_n) + CNT_W'(1);
    assign at_lim = (code_q == '0) || (code_q == CODE_MAX);

    always_comb begin
        if (cnt_q < target)      step = STEP_UP;
        else if (cnt_q > target) step = STEP_DOWN;
        else                     step = STEP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            cnt_q    <= '0;
            primed_q <= 1'b0;
            fault_q  <= 1'b1;
        end else begin
            fault_q <= at_lim | (fault_q & ~fault_clr);
            if (loop_off) begin
                primed_q <= 1'b0;
                cnt_q    <= '0;
                if (ld) code_q <= ld_val;
            end else if (ref_tick) begin
                cnt_q    <= div_rise ? CNT_W'(1) : '0;
                primed_q <= 1'b1;
                if (primed_q) begin
                    case (step)
                        STEP_UP:   if (code_q != CODE_MAX) code_q <= code_q + 1'b1;
                        STEP_DOWN: if (code_q != '0)       code_q <= code_q - 1'b1;
                        default:   code_q <= code_q;
                    endcase
                end
            end else if (div_rise && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign code  = code_q;
    assign fault = fault_q;
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
    import fll_pkg::*;
#(
    parameter int TAP_W       = 5,
    parameter int MOD_W       = 5,
    parameter int ACC_W       = 11,
    parameter int NW          = 10,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ref_lf,
    input  logic                   ref_hf,
    input  logic                   ref_int,
    input  logic [1:0]             ref_sel,
    input  logic [2:0]             ref_div_sel,
    input  logic [NW-1:0]          mult_n,
    input  logic [2:0]             post_div_sel,
    input  logic                   loop_off,
    input  logic                   code_ld,
    input  logic [TAP_W+MOD_W-1:0] code_ld_val,
    input  logic                   fault_clr,
    output logic [TAP_W-1:0]       dco_tap,
    output logic [MOD_W-1:0]       dco_mod,
    output logic                   dco_clk,
    output logic                   dco_div_clk,
    output logic                   dco_fault
);
    localparam int CODE_W = TAP_W + MOD_W;

    logic              ref_tick;
    logic [CODE_W-1:0] code;
    dco_taps_t         taps;

    fll_ref_path #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .ref_in   ({ref_hf, ref_int, ref_lf}),
        .sel      (ref_sel),
        .div_sel  (ref_div_sel),
        .ref_tick (ref_tick)
    );

    fll_dco_model #(.CODE_W(CODE_W), .ACC_W(ACC_W)) u_dco (
        .clk      (clk),
        .rst      (rst),
        .code     (code),
        .post_sel (post_div_sel),
        .taps     (taps)
    );

    fll_loop #(.CODE_W(CODE_W), .NW(NW), .CNT_W(CNT_W)) u_loop (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .div_rise  (taps.div_rise),
        .loop_off  (loop_off),
        .mult_n    (mult_n),
        .ld        (code_ld),
        .ld_val    (code_ld_val),
        .fault_clr (fault_clr),
        .code      (code),
        .fault     (dco_fault)
    );

    assign dco_tap     = code[CODE_W-1:MOD_W];
    assign dco_mod     = code[MOD_W-1:0];
    assign dco_clk     = taps.clk;
    assign dco_div_clk = taps.div_clk;
endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk #(
    parameter int TAP_W = 5,
    parameter int MOD_W = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   loop_off,
    input logic                   code_ld,
    input logic [TAP_W+MOD_W-1:0] code_ld_val,
    input logic                   fault_clr,
    input logic [TAP_W-1:0]       dco_tap,
    input logic [MOD_W-1:0]       dco_mod,
    input logic                   dco_fault
);
    localparam int CW = TAP_W + MOD_W;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] code;
    logic [CW:0]   code_x;
    logic          lim;

    assign code   = {dco_tap, dco_mod};
    assign code_x = {1'b0, code};
    assign lim    = (code == '0) || (code == CMAX);

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(loop_off) |->
            (code_x == $past(code_x) || code_x == $past(code_x) + 1'b1 || code_x + 1'b1 == $past(code_x)));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(loop_off) && !$past(code_ld) |-> $stable(code));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(loop_off) && $past(code_ld) |-> code == $past(code_ld_val));

    // R10
    fault_set_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(lim) |-> dco_fault);

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(dco_fault) && !$past(fault_clr) |-> dco_fault);

    // R10
    fault_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(fault_clr) && !$past(lim) |-> !dco_fault);
endmodule

bind fll_ctrl fll_ctrl_chk #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .loop_off    (loop_off),
    .code_ld     (code_ld),
    .code_ld_val (code_ld_val),
    .fault_clr   (fault_clr),
    .dco_tap     (dco_tap),
    .dco_mod     (dco_mod),
    .dco_fault   (dco_fault)
);

// File: tb/tb_fll_ctrl.sv
`timescale 1ns/1ps
module tb_fll_ctrl;
    localparam int ACC_SPAN = 2048;
    localparam int T_LF  = 3200;
    localparam int T_INT = 96;
    localparam int T_HF  = 64;

    logic       clk = 0, rst = 1;
    logic       ref_lf = 0, ref_hf = 0, ref_int = 0;
    logic [1:0] ref_sel = 0;
    logic [2:0] ref_div_sel = 0;
    logic [9:0] mult_n = 0;
    logic [2:0] post_div_sel = 0;
    logic       loop_off = 1, code_ld = 0, fault_clr = 0;
    logic [9:0] code_ld_val = 0;
    logic [4:0] dco_tap;
    logic [4:0] dco_mod;
    logic       dco_clk, dco_div_clk, dco_fault;

    int total = 0, failed = 0;
    bit finished = 0;

    fll_ctrl dut (
        .clk(clk), .rst(rst), .ref_lf(ref_lf), .ref_hf(ref_hf), .ref_int(ref_int),
        .ref_sel(ref_sel), .ref_div_sel(ref_div_sel), .mult_n(mult_n),
        .post_div_sel(post_div_sel), .loop_off(loop_off), .code_ld(code_ld),
        .code_ld_val(code_ld_val), .fault_clr(fault_clr), .dco_tap(dco_tap),
        .dco_mod(dco_mod), .dco_clk(dco_clk), .dco_div_clk(dco_div_clk),
        .dco_fault(dco_fault)
    );

    initial forever #2.5 clk = ~clk;
    initial forever #(T_INT * 5 / 2) ref_int = ~ref_int;
    initial forever #(T_HF * 5 / 2) ref_hf = ~ref_hf;
    initial forever #(T_LF * 5 / 2) ref_lf = ~ref_lf;

    function automatic int code_now();
        return int'({dco_tap, dco_mod});
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_code(input int v);
        code_ld = 1; code_ld_val = 10'(v);
        @(negedge clk);
        code_ld = 0;
    endtask

    task automatic measure(input int cycles, output int dco_r, output int div_r);
        logic pd, pv;
        dco_r = 0; div_r = 0;
        pd = dco_clk; pv = dco_div_clk;
        repeat (cycles) begin
            @(negedge clk);
            if (dco_clk && !pd) dco_r++;
            if (dco_div_clk && !pv) div_r++;
            pd = dco_clk; pv = dco_div_clk;
        end
    endtask

    function automatic int n_of(input int c);
        case (c) 0: return 1; 1: return 2; 2: return 4; 3: return 8; 4: return 12; default: return 16; endcase
    endfunction

    function automatic int d_of(input int c);
        return (c >= 5) ? 32 : (1 << c);
    endfunction

    // R2 R3 R7 R11: run the loop for one configuration and measure the result
    task automatic run_lock(input string req, input int sel, input int nsel, input int dsel,
                            input int nval, input int tref, input int preload, input int dir);
        int nr, dr, cexp, win, waitc, e, tol, dco_r, div_r, c0, gap;
        nr = n_of(nsel); dr = d_of(dsel);
        cexp = (nval + 1) * dr * ACC_SPAN / (nr * tref);
        win = nr * tref;
        loop_off = 1;
        ref_sel = 2'(sel); ref_div_sel = 3'(nsel); post_div_sel = 3'(dsel); mult_n = 10'(nval);
        @(negedge clk);
        load_code(preload);
        loop_off = 0;
        gap = (cexp > preload) ? cexp - preload : preload - cexp;
        waitc = (gap + 5) * win;
        if (dir != 0) begin
            // R6: early windows move the code one step per window in the right direction
            wait_cyc(3 * win + 100);
            c0 = code_now();
            if (dir > 0) check(c0 >= preload + 1 && c0 <= preload + 4, "R6 step up", c0, preload + 3);
            else         check(c0 <= preload - 1 && c0 >= preload - 4, "R6 step down", c0, preload - 3);
            waitc -= 3 * win + 100;
        end
        check(waitc + 4 * win <= 1024 * win, "R7 settle bound", waitc, 1024 * win);
        wait_cyc(waitc);
        measure(4 * win, dco_r, div_r);
        e = 4 * (nval + 1);
        tol = e / 8 + 3;
        check(div_r >= e - tol && div_r <= e + tol, req, div_r, e);
        check(dco_r >= dr * div_r - dr - 1 && dco_r <= dr * div_r + dr + 1, "R4 raw vs divided", dco_r, dr * div_r);
    endtask

    initial begin
        #(190000 * 5);
        if (!finished) begin
            finished = 1;
            total++; failed++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        int dco_r, div_r, c0;
        wait_cyc(4);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(code_now() == 0, "R1 code", code_now(), 0);
        check(dco_fault == 1, "R1 fault", dco_fault, 1);
        check(dco_clk == 0 && dco_div_clk == 0, "R1 clocks", {dco_clk, dco_div_clk}, 0);

        // R8 load and freeze while the loop is off
        load_code(10'h155);
        check(code_now() == 'h155, "R8 load", code_now(), 'h155);
        wait_cyc(1000);
        check(code_now() == 'h155, "R8 freeze", code_now(), 'h155);

        // R10 fault at max, clear ignored while at limit, clear works away from limit
        load_code(1023);
        @(negedge clk);
        check(dco_fault == 1, "R10 set at max", dco_fault, 1);
        fault_clr = 1; @(negedge clk); fault_clr = 0;
        check(dco_fault == 1, "R10 clear at limit", dco_fault, 1);
        load_code(500);
        wait_cyc(3);
        check(dco_fault == 1, "R10 sticky", dco_fault, 1);
        fault_clr = 1; @(negedge clk); fault_clr = 0;
        check(dco_fault == 0, "R10 cleared", dco_fault, 0);

        // R5 oscillator rate from the code
        load_code(100);
        wait_cyc(16);
        post_div_sel = 0;
        measure(2048, dco_r, div_r);
        check(dco_r >= 99 && dco_r <= 101, "R5 code 100", dco_r, 100);

        // R4 R5 post-divider sweep over every code at code 512
        load_code(512);
        for (int d = 0; d < 8; d++) begin
            post_div_sel = 3'(d);
            wait_cyc(80);
            measure(1024, dco_r, div_r);
            check(dco_r >= 255 && dco_r <= 257, "R5 code 512", dco_r, 256);
            check(div_r >= 256 / d_of(d) - 1 && div_r <= 256 / d_of(d) + 1, "R4 post-divider", div_r, 256 / d_of(d));
        end

        // R3 sweep of pre-divider codes through full locks; R2 sources
        run_lock("R7 R3 n1 internal", 1, 0, 0, 3, T_INT, 0, 1);
        // R9 load while running has no effect
        c0 = code_now();
        load_code(0);
        check(code_now() != 0 && code_now() >= c0 - 1 && code_now() <= c0 + 1, "R9 load ignored", code_now(), c0);
        run_lock("R7 R3 R2 n2 internal alias", 3, 1, 0, 7, T_INT, 76, 0);
        run_lock("R7 R3 R2 n4 hf", 2, 2, 0, 7, T_HF, 56, 0);
        run_lock("R7 R3 n8 D2", 2, 3, 1, 3, T_HF, 28, 0);
        run_lock("R7 R3 n12 from above", 2, 4, 0, 11, T_HF, 40, -1);
        run_lock("R7 R3 n16", 1, 5, 0, 15, T_INT, 16, 0);
        run_lock("R11 R2 N762 lf", 0, 0, 1, 762, T_LF, 968, 0);
        check(code_now() != 0 && code_now() != 1023, "R10 away from limits", code_now(), 976);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule